// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding and Load-Stall Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order integer pipeline, where each of its two source operands should come from. The candidates are the value read from the register file during decode, the result held by the instruction one stage ahead (memory stage), or the result held by the instruction two stages ahead (writeback stage). Alongside the two select codes it drives a stall request for the case where the needed value is still a pending memory load that has not yet returned data.

The unit is purely combinational. It looks only at register indices and write enables. It has no knowledge of whether the execute-stage instruction reads a given operand, so an instruction with no real source field (a jump-and-link, for example) still gets forwarding selects whenever the index bits happen to match. The datapath multiplexers consume the select codes. The pipeline control logic acts on the stall request.

Top module: `operand_fwd_unit`

## Requirements
- R1: When neither later stage qualifies as a producer for an operand, that operand's select is 2'b00 (decode value). The code 2'b11 never appears.
- R2: When the memory-stage instruction has its register-write enable set and a nonzero destination equal to an operand's index, that operand's select is 2'b01.
- R3: When the writeback-stage instruction has its register-write enable set and a nonzero destination equal to an operand's index, and the memory stage does not qualify for that operand, the select is 2'b10.
- R4: When both later stages qualify for the same operand, the memory stage wins and the select is 2'b01.
- R5: A stage whose register-write enable is clear is never a forwarding source, even when its destination index matches. A qualifying stage further back is used instead.
- R6: A destination index of 0 is never forwarded and never raises the stall request.
- R7: The two operands are decided independently. Both may select the same producer. Matching happens regardless of whether the operand is actually used.
- R8: The stall request is 1 exactly when the memory-stage instruction is a load (memory-to-register bit set), has its register-write enable set, has a nonzero destination, and that destination equals the execute-stage rs1 or rs2.
- R9: A match against a load in the memory stage still yields select 2'b01 for the matching operand, in the same cycle that the stall request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs1 | input | IDX_W | First source register index of the execute-stage instruction |
| ex_rs2 | input | IDX_W | Second source register index of the execute-stage instruction |
| mem_rd | input | IDX_W | Destination index of the memory-stage instruction |
| mem_reg_we | input | 1 | Register-write enable of the memory-stage instruction |
| mem_is_load | input | 1 | Memory-to-register (load) bit of the memory-stage instruction |
| wb_rd | input | IDX_W | Destination index of the writeback-stage instruction |
| wb_reg_we | input | 1 | Register-write enable of the writeback-stage instruction |
| op_a_sel | output | 2 | Source select for rs1: 00 decode, 01 memory stage, 10 writeback stage |
| op_b_sel | output | 2 | Source select for rs2, same encoding |
| load_stall | output | 1 | Request to hold the execute stage for one cycle on a load-use dependency |

## Verification
The block holds no state, so a fault can only take the form of a wrong decision, and that wrong decision appears on the select or stall outputs in the same cycle that the offending index pattern is presented. The vectors therefore focus on patterns that would expose a wrong priority or qualification: rd=0 with enables set, matching indices with write enable clear, both stages matching, and a load one stage ahead that matches only one of the two operands. A sweep over every index value confirms that index width and comparison are correct at both ends of the range.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source codes; the datapath mux decodes these positions.
  typedef enum logic [1:0] {
    SRC_DECODE = 2'b00,
    SRC_MEM    = 2'b01,
    SRC_WB     = 2'b10
  } fwd_src_e;

  localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_wr_qual.sv
// Qualifies a later-stage instruction as a forwarding producer.
module fwd_wr_qual #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             wr_en,
  output logic             live
);

  logic dst_nonzero;

  always_comb begin
    dst_nonzero = (dst_idx != '0);
    live        = wr_en && dst_nonzero;
  end

endmodule

// File: rtl/fwd_src_pick.sv
// Chooses the source of one execute-stage operand; newer stage wins.
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic             mem_live,
  input  logic [IDX_W-1:0] mem_dst,
  input  logic             wb_live,
  input  logic [IDX_W-1:0] wb_dst,
  output fwd_src_e         sel
);

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = mem_live && (mem_dst == src_idx);
    wb_hit  = wb_live  && (wb_dst  == src_idx);
    if (mem_hit) begin
      sel = SRC_MEM;
    end else if (wb_hit) begin
      sel = SRC_WB;
    end else begin
      sel = SRC_DECODE;
    end
  end

endmodule

// File: rtl/fwd_load_hazard.sv
// Raises a stall when any operand depends on a load still in the memory stage.
module fwd_load_hazard #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0][IDX_W-1:0] src_idx,
  input  logic                        mem_live,
  input  logic                        mem_is_load,
  input  logic [IDX_W-1:0]            mem_dst,
  output logic                        stall
);

  logic [N_SRC-1:0] dep;

  always_comb begin
    for (int i = 0; i < int'(N_SRC); i++) begin
      dep[i] = (src_idx[i] == mem_dst);
    end
    stall = mem_live && mem_is_load && (|dep);
  end

endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] ex_rs1,
  input  logic [IDX_W-1:0] ex_rs2,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_reg_we,
  input  logic             mem_is_load,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_reg_we,
  output logic [1:0]       op_a_sel,
  output logic [1:0]       op_b_sel,
  output logic             load_stall
);

  logic                                  mem_live;
  logic                                  wb_live;
  logic [NUM_OPERANDS-1:0][IDX_W-1:0]    ex_src;
  fwd_src_e                              sel_w [NUM_OPERANDS];

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  fwd_wr_qual #(.IDX_W(IDX_W)) u_mem_qual (
    .dst_idx (mem_rd),
    .wr_en   (mem_reg_we),
    .live    (mem_live)
  );

  fwd_wr_qual #(.IDX_W(IDX_W)) u_wb_qual (
    .dst_idx (wb_rd),
    .wr_en   (wb_reg_we),
    .live    (wb_live)
  );

  for (genvar g = 0; g < int'(NUM_OPERANDS); g++) begin : g_pick
    fwd_src_pick #(.IDX_W(IDX_W)) u_pick (
      .src_idx  (ex_src[g]),
      .mem_live (mem_live),
      .mem_dst  (mem_rd),
      .wb_live  (wb_live),
      .wb_dst   (wb_rd),
      .sel      (sel_w[g])
    );
  end

  fwd_load_hazard #(.IDX_W(IDX_W), .N_SRC(NUM_OPERANDS)) u_hazard (
    .src_idx     (ex_src),
    .mem_live    (mem_live),
    .mem_is_load (mem_is_load),
    .mem_dst     (mem_rd),
    .stall       (load_stall)
  );

  assign op_a_sel = sel_w[0];
  assign op_b_sel = sel_w[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic [IDX_W-1:0] ex_rs1,
  input logic [IDX_W-1:0] ex_rs2,
  input logic [IDX_W-1:0] mem_rd,
  input logic             mem_reg_we,
  input logic             mem_is_load,
  input logic [IDX_W-1:0] wb_rd,
  input logic             wb_reg_we,
  input logic [1:0]       op_a_sel,
  input logic [1:0]       op_b_sel,
  input logic             load_stall
);

  always_comb begin
    // R1
    sel_legal_chk: assert (op_a_sel != 2'b11 && op_b_sel != 2'b11)
      else $error("select code 11 produced");
    // R2
    mem_src_a_chk: assert (op_a_sel != 2'b01 || (mem_reg_we && mem_rd == ex_rs1))
      else $error("rs1 forwarded from unqualified memory stage");
    // R2
    mem_src_b_chk: assert (op_b_sel != 2'b01 || (mem_reg_we && mem_rd == ex_rs2))
      else $error("rs2 forwarded from unqualified memory stage");
    // R4
    wb_prio_a_chk: assert (op_a_sel != 2'b10 ||
                           (wb_reg_we && wb_rd == ex_rs1 && !(mem_reg_we && mem_rd == ex_rs1)))
      else $error("rs1 writeback select violates priority");
    // R4
    wb_prio_b_chk: assert (op_b_sel != 2'b10 ||
                           (wb_reg_we && wb_rd == ex_rs2 && !(mem_reg_we && mem_rd == ex_rs2)))
      else $error("rs2 writeback select violates priority");
    // R6
    zero_src_chk: assert ((ex_rs1 != '0 || op_a_sel == 2'b00) && (ex_rs2 != '0 || op_b_sel == 2'b00))
      else $error("register 0 forwarded");
    // R8
    stall_cause_chk: assert (!load_stall || (mem_is_load && (op_a_sel == 2'b01 || op_b_sel == 2'b01)))
      else $error("stall without a load dependency");
    // R9
    stall_fwd_chk: assert (!(mem_is_load && (op_a_sel == 2'b01 || op_b_sel == 2'b01)) || load_stall)
      else $error("load dependency without stall");
  end

endmodule

bind operand_fwd_unit fwd_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .ex_rs1      (ex_rs1),
  .ex_rs2      (ex_rs2),
  .mem_rd      (mem_rd),
  .mem_reg_we  (mem_reg_we),
  .mem_is_load (mem_is_load),
  .wb_rd       (wb_rd),
  .wb_reg_we   (wb_reg_we),
  .op_a_sel    (op_a_sel),
  .op_b_sel    (op_b_sel),
  .load_stall  (load_stall)
);

// File: tb/sim_operand_fwd_unit.sv
module sim_operand_fwd_unit;

  localparam int IDX_W  = 5;
  localparam int NREG   = 1 << IDX_W;
  localparam time PERIOD = 4ns;

  typedef struct packed {
    logic [3:0]       rq;
    logic [IDX_W-1:0] rs1;
    logic [IDX_W-1:0] rs2;
    logic [IDX_W-1:0] mrd;
    logic             mwe;
    logic             mld;
    logic [IDX_W-1:0] wrd;
    logic             wwe;
    logic [1:0]       ea;
    logic [1:0]       eb;
    logic             eh;
  } vec_t;

  localparam int NV = 20;
  // fields: rq, rs1, rs2, mem_rd, mem_we, mem_ld, wb_rd, wb_we, exp_a, exp_b, exp_stall
  localparam vec_t VECS [NV] = '{
    '{1, 3, 4, 7, 1, 0, 8, 1, 0, 0, 0},     // R1 no producer matches
    '{2, 6, 2, 6, 1, 0, 9, 1, 1, 0, 0},     // R2 rs1 from memory stage
    '{2, 1, 6, 6, 1, 0, 9, 1, 0, 1, 0},     // R2 rs2 from memory stage
    '{3, 5, 3, 7, 1, 0, 5, 1, 2, 0, 0},     // R3 rs1 from writeback
    '{3, 2, 5, 7, 1, 0, 5, 1, 0, 2, 0},     // R3 rs2 from writeback
    '{4, 9, 9, 9, 1, 0, 9, 1, 1, 1, 0},     // R4 both stages, both operands
    '{4, 9, 4, 9, 1, 0, 4, 1, 1, 2, 0},     // R4 split sources
    '{5, 4, 5, 4, 0, 0, 5, 1, 0, 2, 0},     // R5 memory we clear
    '{5, 4, 2, 4, 0, 0, 4, 1, 2, 0, 0},     // R5 falls back to writeback
    '{5, 4, 4, 4, 0, 0, 4, 0, 0, 0, 0},     // R5 both we clear
    '{6, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0},     // R6 register 0 everywhere
    '{6, 1, 5, 1, 1, 0, 0, 1, 1, 0, 0},     // R6 wb dest 0 ignored
    '{7, 12, 12, 3, 1, 0, 12, 1, 2, 2, 0},  // R7 same producer both operands
    '{8, 1, 7, 1, 1, 1, 0, 0, 1, 0, 1},     // R8 load feeds rs1
    '{8, 7, 1, 1, 1, 1, 0, 0, 0, 1, 1},     // R8 load feeds rs2
    '{8, 2, 3, 1, 1, 1, 0, 0, 0, 0, 0},     // R8 load, no match
    '{8, 1, 2, 1, 0, 1, 0, 0, 0, 0, 0},     // R8 load with we clear
    '{6, 0, 2, 0, 1, 1, 0, 0, 0, 0, 0},     // R6 load to register 0
    '{9, 2, 5, 1, 1, 1, 5, 1, 0, 2, 0},     // R9 load elsewhere, rs2 from wb
    '{9, 31, 31, 31, 1, 1, 0, 0, 1, 1, 1}   // R9 top index, load match
  };

  logic             clk;
  logic             rst_n;
  logic [IDX_W-1:0] ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic             mem_reg_we, mem_is_load, wb_reg_we;
  logic [1:0]       op_a_sel, op_b_sel;
  logic             load_stall;

  int n_chk;
  int n_bad;
  bit done;

  operand_fwd_unit #(.IDX_W(IDX_W)) u0 (
    .ex_rs1      (ex_rs1),
    .ex_rs2      (ex_rs2),
    .mem_rd      (mem_rd),
    .mem_reg_we  (mem_reg_we),
    .mem_is_load (mem_is_load),
    .wb_rd       (wb_rd),
    .wb_reg_we   (wb_reg_we),
    .op_a_sel    (op_a_sel),
    .op_b_sel    (op_b_sel),
    .load_stall  (load_stall)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  task automatic check(input int rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic apply(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b,
                       input logic [IDX_W-1:0] mr, input logic mw, input logic ml,
                       input logic [IDX_W-1:0] wr, input logic ww);
    @(negedge clk);
    ex_rs1 = a; ex_rs2 = b; mem_rd = mr; mem_reg_we = mw; mem_is_load = ml;
    wb_rd = wr; wb_reg_we = ww;
    #1;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    ex_rs1 = '0; ex_rs2 = '0; mem_rd = '0; wb_rd = '0;
    mem_reg_we = 1'b0; mem_is_load = 1'b0; wb_reg_we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // Reset state: idle inputs give decode selects, no stall (R1, R6)
    check(1, "reset op_a_sel", int'(op_a_sel), 0);
    check(1, "reset op_b_sel", int'(op_b_sel), 0);
    check(6, "reset load_stall", int'(load_stall), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].rs1, VECS[i].rs2, VECS[i].mrd, VECS[i].mwe, VECS[i].mld,
            VECS[i].wrd, VECS[i].wwe);
      check(int'(VECS[i].rq), $sformatf("vec %0d op_a_sel", i), int'(op_a_sel), int'(VECS[i].ea));
      check(int'(VECS[i].rq), $sformatf("vec %0d op_b_sel", i), int'(op_b_sel), int'(VECS[i].eb));
      check(int'(VECS[i].rq), $sformatf("vec %0d load_stall", i), int'(load_stall), int'(VECS[i].eh));
    end

    // R2/R3 index sweep: rs1 meets memory stage, rs2 meets writeback
    for (int k = 0; k < NREG; k++) begin
      logic [IDX_W-1:0] ia;
      logic [IDX_W-1:0] ib;
      ia = IDX_W'(k);
      ib = IDX_W'(k + 1);
      apply(ia, ib, ia, 1'b1, 1'b0, ib, 1'b1);
      check(2, $sformatf("sweep %0d op_a_sel", k), int'(op_a_sel), (ia == '0) ? 0 : 1);
      check(3, $sformatf("sweep %0d op_b_sel", k), int'(op_b_sel), (ib == '0) ? 0 : 2);
    end

    // R7 operand not used by a jump-and-link: still forwarded on match
    apply(5'd1, 5'd5, 5'd1, 1'b1, 1'b0, 5'd0, 1'b1);
    check(7, "unused rs1 forwarded", int'(op_a_sel), 1);

    // R8 load matching both operands at once
    apply(5'd14, 5'd14, 5'd14, 1'b1, 1'b1, 5'd14, 1'b1);
    check(8, "double load dep stall", int'(load_stall), 1);
    check(9, "double load dep op_b_sel", int'(op_b_sel), 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule